// File: doc/BRIEF.md
# I2C Write-Only Target with General Call

This block is the receive half of a byte-oriented I2C target. It is driven by a host through a small set of register fields. It watches the bus lines through synchronizers and detects START and STOP conditions. It then compares the first byte after a START with a configured 7-bit address, or with the all-zero general call address when that match is enabled. When the byte matches and carries a write direction bit, the block acknowledges the address and every following data byte, for as long as the host keeps acknowledge enabled.

After each significant event the block raises an interrupt flag and presents a status code. Those events are an address match, a received data byte, and a STOP or repeated START that ends an addressed transfer. While the flag is set, the block holds SCL low. The host reads the status and the received byte, then writes a one to the clear input, and the bus resumes. If the host drops acknowledge enable while a byte's flag is pending, the block answers NACK to the next byte. The block also stops answering its address until acknowledge is enabled again, but it keeps watching the bus the whole time.

Top module: `i2c_tgt_rx`

## Requirements
- R1: `cfg_addr[7:1]` holds the own address. A first byte after START with bits 7:1 equal to it and bit 0 (direction) = 0 is acknowledged: SDA is pulled low during the ninth clock, the flag is set, and the status is 0x60.
- R2: When `cfg_addr[0]` = 1, the first byte 0x00 is acknowledged with status 0x70. When `cfg_addr[0]` = 0, the byte 0x00 is neither acknowledged nor flagged.
- R3: A first byte that does not match, or that carries direction bit 1, gets no acknowledge and no flag. The block then waits for the next START.
- R4: An address is acknowledged only while both `cfg_enable` and `cfg_ack_en` are 1. With `cfg_ack_en` = 0 the own address is ignored. It is answered again at the next START after `cfg_ack_en` returns to 1.
- R5: Data bytes are shifted in MSB first. After each byte the flag is set, `rx_data` holds the byte, and, with `cfg_ack_en` = 1, SDA is pulled low in the ninth clock. The status is 0x80 after an own-address match and 0x90 after a general call.
- R6: If `cfg_ack_en` is 0 when a data byte completes, that byte is flagged with status 0x88 (own address) or 0x98 (general call) and SDA stays released. Later bytes are neither acknowledged nor flagged until a new START.
- R7: A STOP or repeated START during an addressed transfer sets the flag with status 0xA0. An address that follows a repeated START is matched normally.
- R8: While the flag is set, SCL is held low. The flag clears only on a one at `flag_clear` (write-one-to-clear), or when the block is disabled.
- R9: `status` reads 0xF8 whenever the flag is clear. While the flag is set, it reads only one of the codes listed above.
- R10: After reset the flag is clear, the status is 0xF8, and neither bus line is driven.
- R11: With `cfg_enable` = 0 the block sets no flag and drives neither line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| cfg_addr | input | 8 | Own address in bits 7:1, general call enable in bit 0 |
| cfg_enable | input | 1 | Block enable |
| cfg_ack_en | input | 1 | Acknowledge enable |
| flag_clear | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| irq_flag | output | 1 | Interrupt flag |
| status | output | 8 | Status code |
| rx_data | output | 8 | Last received data byte |
| scl_drive_low | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low (acknowledge) |

## Verification
The bench targets address decoding at its edges:
- a general call arriving while general call is disabled;
- a matching address that carries the read bit;
- the all-ones address;
- a configuration where general call is enabled but the own address is sent.

A decoder that ignored the direction bit or the enable bit would acknowledge a byte it should leave alone.

Acknowledge enable is dropped while a flag is pending. The next byte must then be answered with NACK and status 0x88 or 0x98, and the byte after it must be ignored. A design that sampled the enable too late, or stayed addressed, would acknowledge or flag that byte.

SCL must stay low while the flag is set, so a block that failed to stretch would let the bus run on. A repeated START must report 0xA0 and then accept a fresh address.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_DATA,
        ST_DACK
    } tgt_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    localparam byte_t SC_OWN_ACK   = 8'h60;
    localparam byte_t SC_GC_ACK    = 8'h70;
    localparam byte_t SC_OWN_DATA  = 8'h80;
    localparam byte_t SC_OWN_DNACK = 8'h88;
    localparam byte_t SC_GC_DATA   = 8'h90;
    localparam byte_t SC_GC_DNACK  = 8'h98;
    localparam byte_t SC_END       = 8'hA0;
    localparam byte_t SC_NONE      = 8'hF8;

    // {gc_hit, own_hit}; only write direction can hit, general call has priority
    function automatic logic [1:0] addr_match(input byte_t rx_byte, input byte_t cfg);
        logic own_hit;
        logic gc_hit;
        gc_hit  = (rx_byte[BYTE_W-1:1] == '0) && cfg[0] && !rx_byte[0];
        own_hit = (rx_byte[BYTE_W-1:1] == cfg[BYTE_W-1:1]) && !rx_byte[0] && !gc_hit;
        return {gc_hit, own_hit};
    endfunction

    function automatic byte_t data_code(input logic via_gc, input logic acked);
        if (via_gc) return acked ? SC_GC_DATA : SC_GC_DNACK;
        return acked ? SC_OWN_DATA : SC_OWN_DNACK;
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_tgt_edge.sv
module i2c_tgt_edge
    import i2c_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.start    = scl_s && scl_q && sda_q && !sda_s;
        evt.stop     = scl_s && scl_q && !sda_q && sda_s;
        evt.scl_rise = scl_s && !scl_q;
        evt.scl_fall = !scl_s && scl_q;
        evt.sda      = sda_s;
    end

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    input  byte_t    cfg_addr,
    input  logic     cfg_enable,
    input  logic     cfg_ack_en,
    input  logic     flag_clear,
    output logic     flag,
    output byte_t    code,
    output byte_t    data,
    output logic     sda_low
);

    tgt_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    byte_t            shift_q;
    logic             gc_q;
    logic [1:0]       hit;
    logic             addressed;

    assign hit       = addr_match(shift_q, cfg_addr);
    assign addressed = (state_q == ST_AACK) || (state_q == ST_DATA) || (state_q == ST_DACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
            gc_q    <= 1'b0;
            flag    <= 1'b0;
            code    <= SC_NONE;
            data    <= '0;
            sda_low <= 1'b0;
        end else if (!cfg_enable) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            flag    <= 1'b0;
            sda_low <= 1'b0;
        end else begin
            if (flag_clear) flag <= 1'b0;
            if (evt.start || evt.stop) begin
                if (addressed) begin
                    flag <= 1'b1;
                    code <= SC_END;
                end
                state_q <= evt.start ? ST_ADDR : ST_IDLE;
                cnt_q   <= '0;
                sda_low <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_DATA: begin
                        if (evt.scl_rise && cnt_q != CNT_W'(BYTE_W)) begin
                            shift_q <= {shift_q[BYTE_W-2:0], evt.sda};
                            cnt_q   <= cnt_q + 1'b1;
                        end
                        if (evt.scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
                            cnt_q <= '0;
                            if (state_q == ST_ADDR) begin
                                if (cfg_ack_en && (hit != 2'b00)) begin
                                    flag    <= 1'b1;
                                    sda_low <= 1'b1;
                                    gc_q    <= hit[1];
                                    code    <= hit[1] ? SC_GC_ACK : SC_OWN_ACK;
                                    state_q <= ST_AACK;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end else begin
                                flag    <= 1'b1;
                                data    <= shift_q;
                                sda_low <= cfg_ack_en;
                                code    <= data_code(gc_q, cfg_ack_en);
                                state_q <= ST_DACK;
                            end
                        end
                    end
                    ST_AACK, ST_DACK: begin
                        if (evt.scl_fall) begin
                            sda_low <= 1'b0;
                            cnt_q   <= '0;
                            state_q <= (state_q == ST_DACK && !sda_low) ? ST_IDLE : ST_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_tgt_rx.sv
module i2c_tgt_rx
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [7:0] cfg_addr,
    input  logic       cfg_enable,
    input  logic       cfg_ack_en,
    input  logic       flag_clear,
    output logic       irq_flag,
    output logic [7:0] status,
    output logic [7:0] rx_data,
    output logic       scl_drive_low,
    output logic       sda_drive_low
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw_w;
    logic [LINES-1:0] sync_w;
    bus_evt_t         evt_w;
    byte_t            code_w;

    assign raw_w = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        i2c_tgt_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(1'b1)
        ) u_sync (
            .clk(clk),
            .rst(rst),
            .d  (raw_w[g]),
            .q  (sync_w[g])
        );
    end

    i2c_tgt_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .scl_s(sync_w[1]),
        .sda_s(sync_w[0]),
        .evt  (evt_w)
    );

    i2c_tgt_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt_w),
        .cfg_addr  (cfg_addr),
        .cfg_enable(cfg_enable),
        .cfg_ack_en(cfg_ack_en),
        .flag_clear(flag_clear),
        .flag      (irq_flag),
        .code      (code_w),
        .data      (rx_data),
        .sda_low   (sda_drive_low)
    );

    assign status        = irq_flag ? code_w : SC_NONE;
    assign scl_drive_low = irq_flag;

endmodule

// File: rtl/i2c_tgt_rx_chk.sv
module i2c_tgt_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_enable,
    input logic       cfg_ack_en,
    input logic       flag_clear,
    input logic       irq_flag,
    input logic [7:0] status,
    input logic       sda_drive_low
);

    // R8: a pending flag survives until cleared
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !flag_clear && cfg_enable) |=> irq_flag);

    // R8: the flag only drops after a clear strobe or while disabled
    p_clear_only_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_flag) |-> ($past(flag_clear) || !$past(cfg_enable)));

    // R9: a set flag always carries a defined code
    p_valid_code_r9: assert property (@(posedge clk) disable iff (rst)
        irq_flag |-> (status == 8'h60 || status == 8'h70 || status == 8'h80 ||
                      status == 8'h88 || status == 8'h90 || status == 8'h98 ||
                      status == 8'hA0));

    // R4: acknowledge is only driven when enabled
    p_ack_en_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> ($past(cfg_ack_en) && $past(cfg_enable)));

    // R5: every acknowledge comes with a fresh flag
    p_ack_flag_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> $rose(irq_flag));

    // R11: disabled block stays silent
    p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> (!irq_flag && !sda_drive_low));

endmodule

bind i2c_tgt_rx i2c_tgt_rx_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_enable   (cfg_enable),
    .cfg_ack_en   (cfg_ack_en),
    .flag_clear   (flag_clear),
    .irq_flag     (irq_flag),
    .status       (status),
    .sda_drive_low(sda_drive_low)
);

// File: tb/i2c_tgt_rx_bench.sv
module i2c_tgt_rx_bench;

    localparam int Q  = 10;
    localparam int NV = 9;
    // {cfg_addr, first byte, data byte, expected addr status (0 = no ack), expected data status}
    localparam logic [39:0] VEC [NV] = '{
        40'hA4_A4_3C_60_80,
        40'hA5_00_C3_70_90,
        40'hA4_00_00_00_00,
        40'hA4_A5_00_00_00,
        40'hA4_A6_00_00_00,
        40'h15_14_81_60_80,
        40'hFF_FE_00_60_80,
        40'hA5_A4_E7_60_80,
        40'hA5_01_00_00_00
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [7:0] cfg_addr = 8'hA4;
    logic       cfg_enable = 1'b1;
    logic       cfg_ack_en = 1'b1;
    logic       flag_clear = 1'b0;
    logic       irq_flag;
    logic [7:0] status;
    logic [7:0] rx_data;
    logic       scl_drive_low;
    logic       sda_drive_low;
    logic       bus_scl;
    logic       bus_sda;
    logic       drop_ack = 1'b0;
    logic       done = 1'b0;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    assign bus_scl = m_scl & ~scl_drive_low;
    assign bus_sda = m_sda & ~sda_drive_low;

    i2c_tgt_rx u_i2c_tgt_rx (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (bus_scl),
        .sda_i        (bus_sda),
        .cfg_addr     (cfg_addr),
        .cfg_enable   (cfg_enable),
        .cfg_ack_en   (cfg_ack_en),
        .flag_clear   (flag_clear),
        .irq_flag     (irq_flag),
        .status       (status),
        .rx_data      (rx_data),
        .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic wait_high();
        while (!bus_scl) @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk) flag_clear = 1'b1;
        @(negedge clk) flag_clear = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hold();
        m_scl = 1'b1; wait_high(); hold();
        m_sda = 1'b0; hold();
        m_scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold();
        m_scl = 1'b1; wait_high(); hold();
        m_sda = 1'b1; hold();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; hold();
        m_scl = 1'b1; wait_high(); hold();
        m_scl = 1'b0; hold();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked, output logic flagged,
                             output logic [7:0] st, output logic [7:0] dat);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; hold();
        flagged = irq_flag;
        st      = status;
        dat     = rx_data;
        m_scl = 1'b1; hold();
        if (flagged) begin
            chk("R8 SCL held low while flag set", {31'd0, bus_scl}, 32'd0);
            if (drop_ack) begin
                cfg_ack_en = 1'b0;
                drop_ack   = 1'b0;
            end
            clear_flag();
            chk("R8 flag cleared by write-one", {31'd0, irq_flag}, 32'd0);
            chk("R9 idle status after clear", {24'd0, status}, 32'hF8);
        end
        wait_high(); hold();
        acked = !bus_sda;
        m_scl = 1'b0; hold();
    endtask

    task automatic expect_end(input string req, input logic exp_flag);
        repeat (6) @(negedge clk);
        chk(req, {31'd0, irq_flag}, {31'd0, exp_flag});
        if (exp_flag) begin
            chk(req, {24'd0, status}, 32'hA0);
            clear_flag();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog actual=hung expected=completed");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic       ak;
        logic       fl;
        logic [7:0] st;
        logic [7:0] dt;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10 flag after reset", {31'd0, irq_flag}, 32'd0);
        chk("R10 status after reset", {24'd0, status}, 32'hF8);
        chk("R10 SCL released", {31'd0, scl_drive_low}, 32'd0);
        chk("R10 SDA released", {31'd0, sda_drive_low}, 32'd0);

        // R1/R2/R3/R5/R7 vector table
        for (int v = 0; v < NV; v++) begin
            cfg_addr = VEC[v][39:32];
            bus_start();
            send_byte(VEC[v][31:24], ak, fl, st, dt);
            if (VEC[v][15:8] != 8'h00) begin
                chk("R1/R2 address acked", {31'd0, ak}, 32'd1);
                chk("R1/R2 address flagged", {31'd0, fl}, 32'd1);
                chk("R1/R2 address status", {24'd0, st}, {24'd0, VEC[v][15:8]});
                send_byte(VEC[v][23:16], ak, fl, st, dt);
                chk("R5 data acked", {31'd0, ak}, 32'd1);
                chk("R5 data status", {24'd0, st}, {24'd0, VEC[v][7:0]});
                chk("R5 data byte", {24'd0, dt}, {24'd0, VEC[v][23:16]});
                bus_stop();
                expect_end("R7 stop after addressed transfer", 1'b1);
            end else begin
                chk("R3/R2 address not acked", {31'd0, ak}, 32'd0);
                chk("R3/R2 address not flagged", {31'd0, fl}, 32'd0);
                bus_stop();
                expect_end("R3 stop while unaddressed", 1'b0);
            end
        end

        // R6: ack enable dropped during a pending data flag
        cfg_addr = 8'hA4;
        bus_start();
        send_byte(8'hA4, ak, fl, st, dt);
        chk("R6 setup address status", {24'd0, st}, 32'h60);
        drop_ack = 1'b1;
        send_byte(8'h11, ak, fl, st, dt);
        chk("R6 first byte acked", {31'd0, ak}, 32'd1);
        send_byte(8'h22, ak, fl, st, dt);
        chk("R6 next byte nacked", {31'd0, ak}, 32'd0);
        chk("R6 nack status", {24'd0, st}, 32'h88);
        chk("R6 nacked byte latched", {24'd0, dt}, 32'h22);
        send_byte(8'h33, ak, fl, st, dt);
        chk("R6 later byte not acked", {31'd0, ak}, 32'd0);
        chk("R6 later byte not flagged", {31'd0, fl}, 32'd0);
        bus_stop();
        expect_end("R6 stop after nack returns no status", 1'b0);

        // R4: address ignored while ack enable is zero, resumes when set
        bus_start();
        send_byte(8'hA4, ak, fl, st, dt);
        chk("R4 address ignored with ack off", {31'd0, ak}, 32'd0);
        chk("R4 no flag with ack off", {31'd0, fl}, 32'd0);
        bus_stop();
        expect_end("R4 stop while detached", 1'b0);
        cfg_ack_en = 1'b1;
        bus_start();
        send_byte(8'hA4, ak, fl, st, dt);
        chk("R4 address answered again", {31'd0, ak}, 32'd1);
        chk("R4 resumed status", {24'd0, st}, 32'h60);

        // R7: repeated start then fresh address
        bus_start();
        expect_end("R7 repeated start status", 1'b1);
        send_byte(8'hA4, ak, fl, st, dt);
        chk("R7 address after repeated start", {24'd0, st}, 32'h60);
        send_byte(8'h5A, ak, fl, st, dt);
        chk("R5 data after repeated start", {24'd0, dt}, 32'h5A);
        bus_stop();
        expect_end("R7 final stop", 1'b1);

        // R6: general call byte nacked gives 0x98
        cfg_addr = 8'hA5;
        bus_start();
        drop_ack = 1'b1;
        send_byte(8'h00, ak, fl, st, dt);
        chk("R2 general call status", {24'd0, st}, 32'h70);
        send_byte(8'h9C, ak, fl, st, dt);
        chk("R6 general call nack status", {24'd0, st}, 32'h98);
        chk("R6 general call nack on bus", {31'd0, ak}, 32'd0);
        bus_stop();
        expect_end("R6 stop after gc nack", 1'b0);
        cfg_ack_en = 1'b1;

        // R11: disabled block stays off the bus
        cfg_enable = 1'b0;
        bus_start();
        send_byte(8'hA4, ak, fl, st, dt);
        chk("R11 no ack while disabled", {31'd0, ak}, 32'd0);
        chk("R11 no flag while disabled", {31'd0, fl}, 32'd0);
        bus_stop();
        expect_end("R11 stop while disabled", 1'b0);
        cfg_enable = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule